// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous request port and an external asynchronous static RAM that is one byte wide. A user presents a single-word read or write with a valid/ready handshake. The controller then runs the SRAM strobes (chip select, output enable and write strobe, all active low) through a fixed sequence of clock-counted phases. The user sees a one-cycle completion pulse and, for reads, the captured byte.

Every phase length is a whole number of system-clock cycles. Each is computed at elaboration time by rounding a nanosecond minimum up to the clock period. The data bus is split into an output value, an output-enable and an input value, for a pad cell outside the block. Between operations the chip is deselected so that it sits in standby. A write always starts with one cycle in which the controller does not drive the bus. This covers the turnaround after any read.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `op_done` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 exactly when the controller is idle, including the completion cycle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_valid` in any other cycle is ignored and starts no bus activity.
- R3: A read drives `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0, with `mem_addr` equal to the request address. This lasts RD_CYC cycles, starting the cycle after acceptance. RD_CYC = max(2, ceil(T_ACC_NS/CLK_NS)), which is 2 by default.
- R4: At the end of the last read cycle the controller captures `mem_dq_in` into `rd_data`. In the next cycle the bus is idle, `op_done` is 1 for exactly one cycle, and `rd_data` holds the byte.
- R5: A write begins, the cycle after acceptance, with one setup cycle: `mem_cs_n`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R6: The write pulse follows. For PW_CYC = max(1, ceil(max(T_PWE_NS, T_DS_NS)/CLK_NS)) cycles (1 by default), `mem_we_n`=0, `mem_cs_n`=0, `mem_oe_n`=1, `mem_dq_oe`=1, and `mem_dq_out` equals the request data.
- R7: The recovery follows. For REC_CYC = max(1, ceil(T_WC_NS/CLK_NS) - 1 - PW_CYC) cycles (1 by default), `mem_we_n`=1 and `mem_cs_n`=0, while the data is still driven. The bus then goes idle with `op_done`=1 for one cycle and `rd_data` unchanged.
- R8: `mem_dq_oe` is 1 only while `mem_oe_n`=1 and `mem_cs_n`=0.
- R9: `mem_we_n`=0 occurs only with `mem_cs_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1.
- R10: Whenever the controller is idle, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1 and `mem_dq_oe` is 0 (standby).
- R11: The address and write data are latched at acceptance. Changes on `req_addr`, `req_wdata` or `req_write` after acceptance do not reach the bus during that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Word address |
| req_wdata | input | DATA_W (8) | Write byte |
| req_ready | output | 1 | Controller idle, request can be taken |
| op_done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W (8) | Last byte read |
| mem_addr | output | ADDR_W (19) | SRAM address |
| mem_dq_out | output | DATA_W (8) | Value for the data pads |
| mem_dq_oe | output | 1 | Pad drive enable, 1 = controller drives |
| mem_dq_in | input | DATA_W (8) | Value seen on the data pads |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
A phase counter that is off by one shows up as a strobe held low one cycle too long or too short. It can also show up as a completion pulse that arrives a cycle early or late. The per-cycle comparison of all strobes catches this in the first wrong cycle. A sequencer in the wrong state either drives the bus while the SRAM's outputs are enabled, or captures the idle filler value instead of memory data. The first is visible at the pads at once. The second is visible in `rd_data` in the completion cycle. A latch loaded at the wrong time shows up as a changed address or write byte on the bus after the request inputs are scrambled, within one cycle of acceptance.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_WAIT  = 3'd1,
    ST_RD_CAPT  = 3'd2,
    ST_WR_SETUP = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_RECOV = 3'd5
  } seq_state_e;

  // Number of whole clock periods covering a time limit
  function automatic int ceil_cycles(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 2,
  parameter int RD_CYC  = 2,
  parameter int PW_CYC  = 1,
  parameter int REC_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             req_ready
);

  localparam logic [CNT_W-1:0] LEN_RD_WAIT = CNT_W'(RD_CYC - 2);
  localparam logic [CNT_W-1:0] LEN_PULSE   = CNT_W'(PW_CYC - 1);
  localparam logic [CNT_W-1:0] LEN_RECOV   = CNT_W'(REC_CYC - 1);

  assign req_ready = (state_q == ST_IDLE);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = req_write ? ST_WR_SETUP : ST_RD_WAIT;
        end
      end
      ST_RD_WAIT:  if (expired) state_d = ST_RD_CAPT;
      ST_RD_CAPT:  if (expired) state_d = ST_IDLE;
      ST_WR_SETUP: if (expired) state_d = ST_WR_PULSE;
      ST_WR_PULSE: if (expired) state_d = ST_WR_RECOV;
      ST_WR_RECOV: if (expired) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // Phase length loaded on entry to each state
  assign load = (state_d != state_q);

  always_comb begin
    unique case (state_d)
      ST_RD_WAIT:  load_val = LEN_RD_WAIT;
      ST_WR_PULSE: load_val = LEN_PULSE;
      ST_WR_RECOV: load_val = LEN_RECOV;
      default:     load_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // A read capture is always preceded by the access wait (R3)
  assert_capt_after_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_CAPT) |-> ($past(state_q) == ST_RD_WAIT));

  // The write pulse is always preceded by the non-driving setup cycle (R5)
  assert_setup_before_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(state_q == ST_WR_PULSE)) |-> ($past(state_q) == ST_WR_SETUP));

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_q,
  input  seq_state_e        state_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              op_done
);

  logic cs_n_d;
  logic oe_n_d;
  logic we_n_d;
  logic dq_oe_d;
  logic done_d;
  logic capt_en;

  // Strobes are registered from the next state so the pads never glitch
  always_comb begin
    cs_n_d  = (state_d == ST_IDLE);
    oe_n_d  = !((state_d == ST_RD_WAIT) || (state_d == ST_RD_CAPT));
    we_n_d  = (state_d != ST_WR_PULSE);
    dq_oe_d = (state_d == ST_WR_PULSE) || (state_d == ST_WR_RECOV);
    done_d  = (state_q != ST_IDLE) && (state_d == ST_IDLE);
    capt_en = (state_q == ST_RD_CAPT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      op_done   <= 1'b0;
    end else begin
      mem_cs_n  <= cs_n_d;
      mem_oe_n  <= oe_n_d;
      mem_we_n  <= we_n_d;
      mem_dq_oe <= dq_oe_d;
      op_done   <= done_d;
    end
  end

  // Request latches, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  // Read capture at the end of the last access cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (capt_en) begin
      rd_data <= mem_dq_in;
    end
  end

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_cs_n));

  assert_we_framed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

  assert_wdata_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_ACC_NS  = 12,
  parameter int T_PWE_NS  = 10,
  parameter int T_DS_NS   = 7,
  parameter int T_WC_NS   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              op_done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);

  localparam int RD_CYC  = imax(2, ceil_cycles(T_ACC_NS, CLK_NS));
  localparam int PW_CYC  = imax(1, ceil_cycles(imax(T_PWE_NS, T_DS_NS), CLK_NS));
  localparam int WC_CYC  = ceil_cycles(T_WC_NS, CLK_NS);
  localparam int REC_CYC = imax(1, WC_CYC - 1 - PW_CYC);
  localparam int MAX_LEN = imax(RD_CYC, imax(PW_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  seq_state_e       state_q;
  seq_state_e       state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             accept;

  assign accept = req_valid && req_ready;

  sram_seq_fsm #(
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .PW_CYC (PW_CYC),
    .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .expired  (tmr_expired),
    .state_q  (state_q),
    .state_d  (state_d),
    .load     (tmr_load),
    .load_val (tmr_val),
    .req_ready(req_ready)
  );

  sram_phase_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  sram_pin_drive #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .state_d   (state_d),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .rd_data   (rd_data),
    .op_done   (op_done)
  );

  assert_ready_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> (req_ready && mem_cs_n));

  assert_standby_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 8;
  // Bench-side phase lengths from the timing limits (10 ns clock)
  localparam int B_RD  = ((12 + CLK_PERIOD - 1) / CLK_PERIOD < 2) ? 2 : (12 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_PW  = (10 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int B_REC = (((12 + CLK_PERIOD - 1) / CLK_PERIOD) - 1 - B_PW < 1) ? 1
                         : ((12 + CLK_PERIOD - 1) / CLK_PERIOD) - 1 - B_PW;
  localparam int WATCHDOG = 20000;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready;
  logic          op_done;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_in;
  logic          mem_cs_n;
  logic          mem_oe_n;
  logic          mem_we_n;

  sram_async_ctrl i_sram_async_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .op_done   (op_done),
    .rd_data   (rd_data),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_in (mem_dq_in),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- behavioural SRAM ----------------
  logic [DW-1:0] sram_mem [logic [AW-1:0]];

  always @(posedge mem_we_n) begin
    if (rst_n === 1'b1 && mem_cs_n === 1'b0 && mem_dq_oe === 1'b1)
      sram_mem[mem_addr] = mem_dq_out;
  end

  always @(mem_cs_n or mem_oe_n or mem_we_n or mem_addr) begin
    if (mem_cs_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1)
      mem_dq_in = sram_mem.exists(mem_addr) ? sram_mem[mem_addr] : 8'h3C;
    else
      mem_dq_in = 8'hEE;
  end

  // ---------------- reference model ----------------
  // phase codes: 0 reset, 1 idle, 2 read, 3 read done, 4 setup, 5 pulse, 6 recover, 7 write done
  typedef struct {
    int            ph;
    logic          cs_n, oe_n, we_n, dq_oe, done;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic [DW-1:0] rd;
  } exp_t;

  exp_t          q[$];
  exp_t          cur;
  logic          m_ready;
  logic [DW-1:0] last_rd;
  logic [DW-1:0] shadow [logic [AW-1:0]];
  int            n_checks;
  int            n_err;
  bit            finished;

  function automatic exp_t mk(int ph, logic cs, logic oe, logic we, logic dqoe, logic dn,
                              logic [AW-1:0] a, logic [DW-1:0] w, logic [DW-1:0] r);
    exp_t e;
    e.ph = ph; e.cs_n = cs; e.oe_n = oe; e.we_n = we; e.dq_oe = dqoe; e.done = dn;
    e.addr = a; e.wd = w; e.rd = r;
    return e;
  endfunction

  function automatic string ph_req(int ph);
    case (ph)
      0: return "R1";
      1: return "R10";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic push_op(logic wr, logic [AW-1:0] a, logic [DW-1:0] d);
    if (!wr) begin
      logic [DW-1:0] v;
      v = shadow.exists(a) ? shadow[a] : 8'h3C;
      for (int i = 0; i < B_RD; i++) q.push_back(mk(2, 0, 0, 1, 0, 0, a, d, last_rd));
      last_rd = v;
      q.push_back(mk(3, 1, 1, 1, 0, 1, a, d, v));
    end else begin
      q.push_back(mk(4, 0, 1, 1, 0, 0, a, d, last_rd));
      for (int i = 0; i < B_PW; i++)  q.push_back(mk(5, 0, 1, 0, 1, 0, a, d, last_rd));
      for (int i = 0; i < B_REC; i++) q.push_back(mk(6, 0, 1, 1, 1, 0, a, d, last_rd));
      q.push_back(mk(7, 1, 1, 1, 0, 1, a, d, last_rd));
      shadow[a] = d;
    end
  endtask

  initial begin
    cur     = mk(0, 1, 1, 1, 0, 0, '0, '0, '0);
    m_ready = 1'b1;
    last_rd = '0;
  end

  always @(posedge clk) begin
    if (rst_n !== 1'b1) begin
      q.delete();
      cur     = mk(0, 1, 1, 1, 0, 0, '0, '0, '0);
      m_ready = 1'b1;
      last_rd = '0;
    end else begin
      if (m_ready && req_valid === 1'b1) push_op(req_write, req_addr, req_wdata);
      if (q.size() > 0) cur = q.pop_front();
      else              cur = mk(1, 1, 1, 1, 0, 0, '0, '0, last_rd);
      m_ready = (q.size() == 0);
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      string t;
      t = ph_req(cur.ph);
      chk(mem_cs_n  === cur.cs_n,  t, "cs_n",  32'(mem_cs_n),  32'(cur.cs_n));
      chk(mem_oe_n  === cur.oe_n,  t, "oe_n",  32'(mem_oe_n),  32'(cur.oe_n));
      chk(mem_we_n  === cur.we_n,  t, "we_n",  32'(mem_we_n),  32'(cur.we_n));
      chk(mem_dq_oe === cur.dq_oe, t, "dq_oe", 32'(mem_dq_oe), 32'(cur.dq_oe));
      chk(op_done   === cur.done,  (cur.done ? "R4" : t), "op_done", 32'(op_done), 32'(cur.done));
      chk(req_ready === m_ready,   "R2", "req_ready", 32'(req_ready), 32'(m_ready));
      if (!cur.cs_n)
        chk(mem_addr === cur.addr, "R11", "mem_addr", 32'(mem_addr), 32'(cur.addr));
      if (cur.dq_oe)
        chk(mem_dq_out === cur.wd, "R11", "mem_dq_out", 32'(mem_dq_out), 32'(cur.wd));
      if (cur.done)
        chk(rd_data === cur.rd, "R4", "rd_data", 32'(rd_data), 32'(cur.rd));
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    logic rdy;
    @(negedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      rdy = req_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk); #2;
    end
    // Scrambled request held while busy: must be ignored (R2, R11)
    @(negedge clk); #2;
    req_write = !wr; req_addr = ~a; req_wdata = ~d;
    @(negedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    n_checks = 0; n_err = 0; finished = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);          // R1 reset state checked each cycle
    rst_n = 1'b1;
    idle_cycles(3);                      // R10 standby
    issue(1'b0, 19'h00000, 8'h00);       // R3 R4 read of unwritten word
    issue(1'b1, 19'h12345, 8'h5A);       // R5 R6 R7 write
    issue(1'b0, 19'h12345, 8'h00);       // R4 read back
    issue(1'b1, 19'h7FFFF, 8'hC3);       // read -> write turnaround, top address
    issue(1'b1, 19'h00000, 8'h81);       // back-to-back write, address zero
    issue(1'b0, 19'h7FFFF, 8'h00);
    issue(1'b0, 19'h00000, 8'h00);
    idle_cycles(5);
    issue(1'b1, 19'h2AAAA, 8'hFF);
    issue(1'b0, 19'h2AAAA, 8'h00);
    issue(1'b1, 19'h2AAAA, 8'h00);
    issue(1'b0, 19'h2AAAA, 8'h00);
    issue(1'b0, 19'h55555, 8'h00);
    idle_cycles(8);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule